// File: doc/BRIEF.md
# High-Frequency Clock Source Switcher with Deferred Changeover

This block chooses which of two high-frequency oscillators drives the system high-frequency clock. Source 0 is the RC oscillator. Source 1 is the crystal oscillator. Software changes the source in two steps.

In the first step, software writes the select input. The chosen oscillator is enabled at once, and its ready input is then qualified over a programmable number of control-clock cycles. When qualification is complete, a pending flag is raised. The output clock still comes from the old source at this point.

In the second step, software sets the allow-switch input. The control logic then commits the new source. A break-before-make gated mux hands the output over without producing a shortened clock phase. The pending flag stays up until the output is seen running from the new source, and then it drops. The current-source status always shows the source that is actually gated onto the output.

If software returns the select input to the active source before the changeover, the request is withdrawn. The pending flag drops and the unused oscillator is disabled again.

Top module: `hfsw_clk_switch`

## Requirements
- R1: The select encoding is 0 = RC source and 1 = crystal source. After a completed changeover, `cur_src` equals the select value and `clk_out` runs at that source's period.
- R2: While `allow_sw` is 0, the committed source, `cur_src` and the `clk_out` period do not change, whatever `sel_xo` and the ready inputs do.
- R3: One control-clock cycle after `sel_xo` selects a source, that source's enable bit (`osc_en[0]` = RC, `osc_en[1]` = crystal) is 1, even when switching is not allowed.
- R4: With the selected source's ready input held high from the cycle the request appears, `switch_pending` is 0 for the first `qual_len` control-clock edges and 1 from edge `qual_len`+1.
- R5: With `allow_sw` at 1 and qualification complete, the switch is committed. `switch_pending` stays 1 while the mux hands over and returns to 0 once `cur_src` shows the new source.
- R6: If `sel_xo` returns to the active source before commit, `switch_pending` is 0 on the next edge and the unused source's enable drops.
- R7: `clk_out` never has a high or low phase shorter than the shorter half-period of the two sources, and at most one source gate is open at any time.
- R8: After reset, `cur_src` = 0, `osc_en` = 2'b01, `switch_pending` = 0 and `clk_out` follows the RC source.
- R9: If the ready input drops during qualification, the count restarts. Pending then needs `qual_len`+1 further edges of continuous ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_xo | input | 1 | Requested source: 0 RC, 1 crystal |
| allow_sw | input | 1 | Permission to perform the changeover |
| qual_len | input | CNT_W | Ready cycles needed before pending is raised |
| src_ready | input | 2 | Per-source qualified/ready indication |
| src_clk | input | 2 | Source clocks: bit 0 RC, bit 1 crystal |
| clk_out | output | 1 | Glitch-free selected high-frequency clock |
| switch_pending | output | 1 | New source ready and changeover not yet finished |
| cur_src | output | 1 | Source currently gated onto `clk_out` |
| osc_en | output | 2 | Oscillator enables, bit 0 RC, bit 1 crystal |

## Verification
The bench sweeps the qualification length over 0 to 4 and switches in both directions at each length. This separates an off-by-one in the pending edge from a wrong comparison direction.

Each request is first held without permission, which tells a premature commit apart from a correct hold. Permission is then given afterwards in some runs and beforehand in others. Giving it beforehand exposes a pending flag that clears at commit instead of at completion.

Withdrawn requests and interrupted ready pulses tell apart stale counters and enables that stay on too long. Phase widths of the output clock are timed throughout the run, and the output period is measured against both sources.

// File: rtl/hfsw_pkg.sv
`timescale 1ns/1ps
package hfsw_pkg;
    localparam int NUM_SRC = 2;

    typedef enum logic {
        SRC_RC = 1'b0,
        SRC_XO = 1'b1
    } src_t;

    typedef struct packed {
        src_t                cur;     // committed mux target
        src_t                status;  // source observed on the output
        logic                pending;
        logic [NUM_SRC-1:0]  en;
        logic [NUM_SRC-1:0]  sync1;
        logic [NUM_SRC-1:0]  sync2;
    } policy_t;
endpackage

// File: rtl/hfsw_qualifier.sv
`timescale 1ns/1ps
module hfsw_qualifier #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             rdy,
    input  logic [CNT_W-1:0] qual_len,
    output logic             qualified
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!req || !rdy) begin
            cnt_d = '0;
        end else if (cnt_q < qual_len) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign qualified = req && rdy && (cnt_q >= qual_len);
endmodule

// File: rtl/hfsw_gate_cell.sv
`timescale 1ns/1ps
module hfsw_gate_cell #(
    parameter bit RESET_ON = 1'b0
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic want,
    input  logic other_on,
    output logic gate
);
    logic s1_q, s2_q, gate_q;
    logic req_d;

    // break-before-make: open only after the other gate is seen closed
    always_comb req_d = want && !other_on;

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RESET_ON;
            s2_q <= RESET_ON;
        end else begin
            s1_q <= req_d;
            s2_q <= s1_q;
        end
    end

    // change the gate only while the source clock is low
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) gate_q <= RESET_ON;
        else        gate_q <= s2_q;
    end

    assign gate = gate_q;
endmodule

// File: rtl/hfsw_policy.sv
`timescale 1ns/1ps
module hfsw_policy
    import hfsw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_xo,
    input  logic               allow_sw,
    input  logic               qualified,
    input  logic [NUM_SRC-1:0] gate_raw,
    output logic               req,
    output src_t               cur,
    output src_t               status,
    output logic               pending,
    output logic [NUM_SRC-1:0] en
);
    policy_t p_d, p_q;
    src_t    sel;

    always_comb begin
        sel = src_t'(sel_xo);
        req = (sel != p_q.cur);
        p_d = p_q;

        p_d.sync1 = gate_raw;
        p_d.sync2 = p_q.sync1;

        if (req && qualified && allow_sw) begin
            p_d.cur = sel;
        end

        if (p_q.sync2 == 2'b10)      p_d.status = SRC_XO;
        else if (p_q.sync2 == 2'b01) p_d.status = SRC_RC;

        p_d.pending = (req && qualified) || (p_q.cur != p_q.status);

        for (int s = 0; s < NUM_SRC; s++) begin
            p_d.en[s] = (sel == src_t'(s)) || (p_q.cur == src_t'(s))
                     || (p_q.status == src_t'(s));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.cur     <= SRC_RC;
            p_q.status  <= SRC_RC;
            p_q.pending <= 1'b0;
            p_q.en      <= 2'b01;
            p_q.sync1   <= 2'b01;
            p_q.sync2   <= 2'b01;
        end else begin
            p_q <= p_d;
        end
    end

    assign cur     = p_q.cur;
    assign status  = p_q.status;
    assign pending = p_q.pending;
    assign en      = p_q.en;
endmodule

// File: rtl/hfsw_clk_switch.sv
`timescale 1ns/1ps
module hfsw_clk_switch
    import hfsw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_xo,
    input  logic             allow_sw,
    input  logic [CNT_W-1:0] qual_len,
    input  logic [1:0]       src_ready,
    input  logic [1:0]       src_clk,
    output logic             clk_out,
    output logic             switch_pending,
    output logic             cur_src,
    output logic [1:0]       osc_en
);
    logic               req, qualified;
    src_t               cur_q, status_q;
    logic [NUM_SRC-1:0] gate_on;
    logic [NUM_SRC-1:0] gated_clk;

    hfsw_qualifier #(.CNT_W(CNT_W)) qual_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .rdy       (src_ready[sel_xo]),
        .qual_len  (qual_len),
        .qualified (qualified)
    );

    hfsw_policy policy_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_xo    (sel_xo),
        .allow_sw  (allow_sw),
        .qualified (qualified),
        .gate_raw  (gate_on),
        .req       (req),
        .cur       (cur_q),
        .status    (status_q),
        .pending   (switch_pending),
        .en        (osc_en)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        hfsw_gate_cell #(.RESET_ON(s == 0)) cell_i (
            .clk_src  (src_clk[s]),
            .rst_n    (rst_n),
            .want     (cur_q == src_t'(s)),
            .other_on (gate_on[NUM_SRC-1-s]),
            .gate     (gate_on[s])
        );
        assign gated_clk[s] = src_clk[s] & gate_on[s];
    end

    assign clk_out = |gated_clk;
    assign cur_src = status_q;
endmodule

// File: rtl/hfsw_clk_switch_chk.sv
`timescale 1ns/1ps
module hfsw_clk_switch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_xo,
    input logic       allow_sw,
    input logic       cur_src,
    input logic       switch_pending,
    input logic [1:0] osc_en,
    input logic       cur_q,
    input logic [1:0] gate_on
);
    AST_ONE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_on));                                           // R7
    AST_NO_COMMIT_WO_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !allow_sw |=> $stable(cur_q));                                // R2
    AST_XO_EN_ON_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        sel_xo |=> osc_en[1]);                                        // R3
    AST_RC_EN_ON_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_xo |=> osc_en[0]);                                       // R3
    AST_REVERT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_xo == cur_q) && (cur_q == cur_src) |=> !switch_pending); // R6
endmodule

bind hfsw_clk_switch hfsw_clk_switch_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .sel_xo         (sel_xo),
    .allow_sw       (allow_sw),
    .cur_src        (cur_src),
    .switch_pending (switch_pending),
    .osc_en         (osc_en),
    .cur_q          (cur_q),
    .gate_on        (gate_on)
);

// File: tb/hfsw_clk_switch_tb_top.sv
`timescale 1ns/1ps
module hfsw_clk_switch_tb_top;
    localparam real HALF_RC = 7.0;
    localparam real HALF_XO = 11.0;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       sel_xo = 1'b0, allow_sw = 1'b0;
    logic [7:0] qual_len = 8'd3;
    logic [1:0] src_ready = 2'b11;
    logic [1:0] src_clk = 2'b00;
    logic       clk_out, switch_pending, cur_src;
    logic [1:0] osc_en;

    int  n_chk = 0, n_bad = 0, glitches = 0;
    bit  done = 0, mon_on = 0, mon_armed = 0;
    real last_t = 0.0;

    always #2.5 clk = ~clk;
    always #(HALF_RC) src_clk[0] = ~src_clk[0];
    always #(HALF_XO) src_clk[1] = ~src_clk[1];

    hfsw_clk_switch dut_i (
        .clk(clk), .rst_n(rst_n), .sel_xo(sel_xo), .allow_sw(allow_sw),
        .qual_len(qual_len), .src_ready(src_ready), .src_clk(src_clk),
        .clk_out(clk_out), .switch_pending(switch_pending),
        .cur_src(cur_src), .osc_en(osc_en)
    );

    // phase-width monitor, R7
    always @(clk_out) begin
        if (mon_on) begin
            if (mon_armed && ($realtime - last_t) < HALF_RC - 0.5) glitches++;
            mon_armed = 1;
            last_t = $realtime;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $realtime);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_period(input bit src, input string req);
        real t0, p, e;
        e = src ? 2.0 * HALF_XO : 2.0 * HALF_RC;
        @(posedge clk_out); t0 = $realtime;
        @(posedge clk_out); p = $realtime - t0;
        check((p > e - 0.5) && (p < e + 0.5), req, int'(p), int'(e));
        tick(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        bit cs;
        #50; rst_n = 1'b1;
        tick(2);
        mon_on = 1;
        // R8 reset state
        check(cur_src == 1'b0, "R8 cur_src", cur_src, 0);
        check(osc_en == 2'b01, "R8 osc_en", osc_en, 1);
        check(switch_pending == 1'b0, "R8 pending", switch_pending, 0);
        check_period(1'b0, "R8 clk_out period");

        cs = 1'b0;
        for (int len = 0; len <= 4; len++) begin
            for (int dir = 0; dir < 2; dir++) begin
                qual_len = 8'(len);
                sel_xo = ~cs;
                for (int k = 1; k <= len + 2; k++) begin
                    tick(1);
                    check(switch_pending == (k >= len + 1), "R4 pending timing",
                          switch_pending, (k >= len + 1));
                    if (k == 1) check(osc_en[~cs] == 1'b1, "R3 new enable", osc_en, 3);
                end
                tick(30);
                check(cur_src == cs, "R2 held source", cur_src, cs);
                check(switch_pending == 1'b1, "R2 still pending", switch_pending, 1);
                check_period(cs, "R2 period held");
                if (len == 2) begin
                    sel_xo = cs;
                    tick(1);
                    check(switch_pending == 1'b0, "R6 pending cleared", switch_pending, 0);
                    tick(1);
                    check(osc_en == (cs ? 2'b10 : 2'b01), "R6 unused enable off",
                          osc_en, cs ? 2 : 1);
                    sel_xo = ~cs;
                    tick(len + 2);
                end
                if (dir == 1) begin
                    // permission given while already pending
                    allow_sw = 1'b1;
                    tick(60);
                end else begin
                    // permission given before the request: pending spans handover
                    sel_xo = cs;
                    tick(3);
                    allow_sw = 1'b1;
                    sel_xo = ~cs;
                    tick(len + 2);
                    check(switch_pending == 1'b1 && cur_src == cs, "R5 pending during handover",
                          {switch_pending, cur_src}, {1'b1, cs});
                    tick(60);
                end
                check(cur_src == ~cs, "R1 cur_src after switch", cur_src, ~cs);
                check(switch_pending == 1'b0, "R5 pending cleared", switch_pending, 0);
                check(osc_en == (cs ? 2'b01 : 2'b10), "R1 enables after switch",
                      osc_en, cs ? 1 : 2);
                check_period(~cs, "R1 clk_out period");
                allow_sw = 1'b0;
                cs = ~cs;
                tick(2);
            end
        end

        // R9 ready interruption restarts qualification
        qual_len = 8'd4;
        src_ready[~cs] = 1'b0;
        sel_xo = ~cs;
        tick(10);
        check(switch_pending == 1'b0, "R9 no ready no pending", switch_pending, 0);
        check(osc_en[~cs] == 1'b1, "R3 enable without ready", osc_en, 3);
        src_ready[~cs] = 1'b1; tick(3);
        src_ready[~cs] = 1'b0; tick(1);
        src_ready[~cs] = 1'b1;
        tick(4);
        check(switch_pending == 1'b0, "R9 count restarted", switch_pending, 0);
        tick(1);
        check(switch_pending == 1'b1, "R9 pending after restart", switch_pending, 1);
        check(cur_src == cs, "R2 no allow no switch", cur_src, cs);
        sel_xo = cs;
        tick(3);
        check(switch_pending == 1'b0, "R6 withdraw", switch_pending, 0);

        tick(5);
        check(glitches == 0, "R7 short phase count", glitches, 0);
        finish_run();
    end
endmodule